// File: doc/BRIEF.md
# Six-Bit Binary Rate Multiplier Stage

This block turns a steady clock into a thinned pulse train whose density is set by a rate word. A free-running counter steps through 2^W states, W being 6 by default. Each state is matched against a set of nested low-bit patterns, one pattern per rate bit. The matches a rate word selects never coincide, so over one full counter cycle the number of output pulses equals the rate word read as a binary number. The pulses are also spread evenly across the cycle rather than bunched together.

Pulses are shaped by the clock itself. A selected count drives the active-low pulse output only while the clock is low and a strobe input is low. A second output combines the pulse with a cascade input. When several stages are chained, that output lets a downstream stage be forced inactive. An active-low carry output marks the last count of the cycle, so a following stage can use it as its count enable. The clear is asynchronous and active-high. It forces the counter to zero, and the outputs follow at once.

Top module: `brm_stage`

## Requirements
- R1: On a rising clock edge with `count_en_n` low and `clear` low, the counter advances by one and wraps from 2^W-1 to 0. Over any 2^W consecutive enabled clocks, `carry_n` is low in exactly one low phase.
- R2: While `clear` is high, the counter is held at zero. The outputs reflect count zero immediately, without waiting for a clock edge.
- R3: While `count_en_n` is high, the counter holds its value across clock edges.
- R4: Rate bit W-1, the highest weight, selects every count whose bit 0 is 0. That gives 2^(W-1) pulses per cycle.
- R5: Rate bit W-1-j (j ≥ 1) selects the counts whose low j+1 bits are a 0 at bit j followed by ones in bits j-1..0. The selected sets are disjoint, so over 2^W enabled clocks the number of pulses equals the rate value.
- R6: `pulse_n` is low only when the current count is selected, the clock is low and `strobe_n` is low. It is high at all other times.
- R7: `gated_out` is the NAND of `pulse_n` and `cascade_in`. It is high whenever `cascade_in` is low and equals the inverse of `pulse_n` when `cascade_in` is high.
- R8: `carry_n` is low exactly when the count is 2^W-1 and `count_en_n` is low.
- R9: A change on `rate` takes effect on the outputs at once, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the count advances on the rising edge, and pulses fall in the low phase |
| clear | input | 1 | Asynchronous active-high counter clear |
| count_en_n | input | 1 | Active-low count enable |
| strobe_n | input | 1 | Active-low pulse gate |
| cascade_in | input | 1 | Cascade/unity input for `gated_out` |
| rate | input | W | Rate word, MSB has the highest weight |
| pulse_n | output | 1 | Active-low rate pulse |
| gated_out | output | 1 | NAND of `pulse_n` and `cascade_in` |
| carry_n | output | 1 | Active-low end-of-cycle enable for the next stage |

## Verification
The hardest case to reach is the immediate effect of an asynchronous clear. The clear must arrive in the middle of a low clock phase, while the count is odd, under a rate word that selects only even counts. In that state the pulse output must drop at once with no clock edge, and the stimulus reaches it by stepping the clock until the count is odd. A second hard case is a hold at a selected count, which is reached by counting to 31 and then releasing the enable. All 64 rate words are swept, each across a full counter cycle, and the pulse totals are compared with the rate value. Meanwhile a behavioural model checks every high and low phase.

// File: rtl/brm_pkg.sv
package brm_pkg;
   localparam int unsigned BRM_MIN_W = 1;
   localparam int unsigned BRM_MAX_W = 16;

   typedef struct packed {
      logic pulse;
      logic last;
   } brm_sel_t;
endpackage

// File: rtl/brm_count.sv
module brm_count #(
   parameter int unsigned W = 6
) (
   input  logic         clk,
   input  logic         clear,
   input  logic         en_n,
   output logic [W-1:0] cnt,
   output logic         last
);
   always_ff @(posedge clk or posedge clear) begin
      if (clear) cnt <= '0;
      else if (!en_n) cnt <= cnt + 1'b1;
   end

   assign last = &cnt;

   p_step_r1: assert property (@(posedge clk) disable iff (clear)
      !en_n |=> cnt == $past(cnt) + 1'b1);
   p_hold_r3: assert property (@(posedge clk) disable iff (clear)
      en_n |=> $stable(cnt));
   p_clear_r2: assert property (@(posedge clk) clear |-> cnt == '0);
endmodule

// File: rtl/brm_decode.sv
module brm_decode #(
   parameter int unsigned W = 6
) (
   input  logic         clk,
   input  logic         clear,
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] rate,
   output logic         sel
);
   logic [W-1:0] hit;

   for (genvar j = 0; j < W; j++) begin : g_prefix
      localparam logic [W-1:0] MASK = (W'(1) << (j + 1)) - W'(1);
      localparam logic [W-1:0] PAT  = (W'(1) << j) - W'(1);
      assign hit[W-1-j] = rate[W-1-j] && ((cnt & MASK) == PAT);
   end

   assign sel = |hit;

   p_disjoint_r5: assert property (@(posedge clk) disable iff (clear)
      $onehot0(hit));
endmodule

// File: rtl/brm_gate.sv
module brm_gate (
   input  logic clk,
   input  logic strobe_n,
   input  logic cascade_in,
   input  logic en_n,
   input  logic sel,
   input  logic last,
   output logic pulse_n,
   output logic gated_out,
   output logic carry_n
);
   logic fire;

   always_comb begin
      fire      = sel & ~clk & ~strobe_n;
      pulse_n   = ~fire;
      gated_out = ~(pulse_n & cascade_in);
      carry_n   = ~(last & ~en_n);
   end

   p_strobe_r6: assert property (@(posedge clk) strobe_n |-> pulse_n);
   p_cascade_r7: assert property (@(posedge clk) !cascade_in |-> gated_out);
endmodule

// File: rtl/brm_stage.sv
module brm_stage #(
   parameter int unsigned W = 6
) (
   input  logic         clk,
   input  logic         clear,
   input  logic         count_en_n,
   input  logic         strobe_n,
   input  logic         cascade_in,
   input  logic [W-1:0] rate,
   output logic         pulse_n,
   output logic         gated_out,
   output logic         carry_n
);
   import brm_pkg::*;

   if (W < BRM_MIN_W || W > BRM_MAX_W) begin : g_bad_width
      $error("brm_stage: W out of range");
   end

   logic [W-1:0] cnt;
   brm_sel_t     s;

   brm_count #(.W(W)) u_count (
      .clk(clk), .clear(clear), .en_n(count_en_n), .cnt(cnt), .last(s.last)
   );

   brm_decode #(.W(W)) u_decode (
      .clk(clk), .clear(clear), .cnt(cnt), .rate(rate), .sel(s.pulse)
   );

   brm_gate u_gate (
      .clk(clk), .strobe_n(strobe_n), .cascade_in(cascade_in),
      .en_n(count_en_n), .sel(s.pulse), .last(s.last),
      .pulse_n(pulse_n), .gated_out(gated_out), .carry_n(carry_n)
   );

   p_carry_r8: assert property (@(posedge clk) disable iff (clear)
      !carry_n |-> (!count_en_n && cnt == {W{1'b1}}));
endmodule

// File: tb/brm_stage_tb.sv
module brm_stage_tb;
   localparam int W = 6;
   localparam int N = 1 << W;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic clear = 1'b0, en_n = 1'b1, strobe_n = 1'b0, casc = 1'b1;
   logic [W-1:0] rate = '0;
   logic pulse_n, gated_out, carry_n;

   int total = 0, bad = 0, mcnt = 0, pulses = 0, carries = 0;
   bit done = 0;

   brm_stage #(.W(W)) u_dut (
      .clk(clk), .clear(clear), .count_en_n(en_n), .strobe_n(strobe_n),
      .cascade_in(casc), .rate(rate), .pulse_n(pulse_n),
      .gated_out(gated_out), .carry_n(carry_n)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   function automatic bit picked(input int c, input logic [W-1:0] r);
      for (int j = 0; j < W; j++)
         if (r[W-1-j] && (c % (1 << (j + 1))) == (1 << j) - 1) return 1'b1;
      return 1'b0;
   endfunction

   task automatic check_now(input string req);
      bit ez, ey, ec;
      ez = !(!clk && !strobe_n && picked(mcnt, rate));
      ey = !(ez && casc);
      ec = !(mcnt == N - 1 && !en_n);
      chk(pulse_n === ez, {req, "/R6 pulse_n"}, int'(pulse_n), int'(ez));
      chk(gated_out === ey, {req, "/R7 gated_out"}, int'(gated_out), int'(ey));
      chk(carry_n === ec, {req, "/R8 carry_n"}, int'(carry_n), int'(ec));
   endtask

   task automatic tick(input string req);
      @(posedge clk);
      if (!clear && !en_n) mcnt = (mcnt + 1) % N;
      #2 check_now(req);
      @(negedge clk);
      #2 check_now(req);
      if (!pulse_n) pulses++;
      if (!carry_n) carries++;
   endtask

   initial begin
      #1 clear = 1'b1;
      #1 check_now("R2 reset");
      en_n = 1'b0;
      rate = 6'b100000;
      for (int i = 0; i < 3; i++) tick("R2 held");
      chk(mcnt == 0, "R2", mcnt, 0);
      clear = 1'b0;

      for (int r = 0; r < N; r++) begin
         rate = r[W-1:0];
         #1 check_now("R9 rate change");
         pulses = 0; carries = 0;
         for (int i = 0; i < N; i++) tick("R5 sweep");
         chk(pulses == r, r == 32 ? "R4 msb weight" : "R5 total", pulses, r);
         chk(carries == 1, "R1 wrap carry", carries, 1);
      end

      rate = 6'b000001;
      while (mcnt != 31) tick("R1 advance");
      en_n = 1'b1;
      pulses = 0;
      for (int i = 0; i < 5; i++) tick("R3 hold");
      chk(pulses == 5, "R3 hold pulses", pulses, 5);
      en_n = 1'b0;
      while (mcnt != N - 1) tick("R1 advance");
      en_n = 1'b1;
      #1 check_now("R8 carry gated by enable");
      carries = 0;
      for (int i = 0; i < 4; i++) tick("R3 hold at top");
      chk(carries == 0, "R8 no carry while disabled", carries, 0);
      en_n = 1'b0;

      strobe_n = 1'b1;
      rate = '1;
      pulses = 0;
      for (int i = 0; i < N; i++) tick("R6 strobe");
      chk(pulses == 0, "R6 strobe blocks", pulses, 0);
      strobe_n = 1'b0;

      casc = 1'b0;
      for (int i = 0; i < 10; i++) begin
         tick("R7 cascade low");
         chk(gated_out === 1'b1, "R7 forced high", int'(gated_out), 1);
      end
      casc = 1'b1;

      rate = 6'b100000;
      tick("R4");
      if (mcnt % 2 == 0) tick("R4");
      chk(pulse_n === 1'b1, "R4 odd count idle", int'(pulse_n), 1);
      clear = 1'b1;
      mcnt = 0;
      #1 check_now("R2 async");
      chk(pulse_n === 1'b0, "R2 async clear pulse", int'(pulse_n), 0);
      tick("R2 held");
      clear = 1'b0;
      for (int i = 0; i < 4; i++) tick("R1 restart");

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=0 exp=1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule